// File: doc/BRIEF.md
# Chopper Channel Sequencer with Sign Demodulation

This block controls the input multiplexer and the amplifier gain of a measurement front end. It also removes the chopper modulation from the converted samples that come back. With the chopper off, the multiplexer and gain lines simply follow the user settings.

With the chopper on, the block uses two differential inputs that are wired to each other with swapped polarity outside the chip. It alternates between these two inputs over a period of four phases. A phase ends only when the conversion timing sends a strobe, which marks that a settled group of conversions is complete. Samples taken on the reversed input are negated, and samples taken on the direct input are passed unchanged. Summing the results downstream therefore adds the signal and cancels any error that stays constant over one chopper period, such as amplifier offset and drift.

Each output sample carries the sign that was in effect in the cycle in which that sample arrived. When the strobe and a sample fall in the same cycle, the sample belongs to the phase that is ending.

Top module: `chopper_mux_sequencer`

## Requirements
- R1: While reset is active, and until the synchronised reset is released, `mux_sel`, `gain_code`, `neg_flag`, `out_valid` and `out_data` are all zero.
- R2: With `chop_en` low, `mux_sel` equals the `usr_chan` value of the previous cycle, and `neg_flag` is 0.
- R3: `gain_code` equals the `usr_gain` value of the previous cycle, whether or not the chopper is enabled.
- R4: With the chopper active, the phase index runs 0,1,2,3 and then repeats. `mux_sel` is channel code 0 in phases 0 and 2, and channel code 1 in phases 1 and 3. `neg_flag` is 1 exactly when `mux_sel` is 1.
- R5: While the chopper stays enabled, the phase moves forward by exactly one step for each cycle with `phase_adv` high. In every other cycle it holds.
- R6: A cycle in which `chop_en` goes from 0 to 1 starts the period at phase 0, so `mux_sel` becomes 0. A `phase_adv` strobe in that same cycle is ignored.
- R7: One cycle after a cycle with `smp_valid` high, `out_data` holds the sample. The sample is unchanged if `neg_flag` was 0 in its cycle, and is the two's-complement negation if `neg_flag` was 1.
- R8: A sample equal to the most negative value (0x8000 for 16 bits) that arrives while `neg_flag` is 1 produces the most positive value (0x7FFF).
- R9: `out_valid` equals the `smp_valid` value of the previous cycle. `out_data` keeps its value after a cycle without a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chop_en | input | 1 | Selects chopper mode when high |
| phase_adv | input | 1 | One-cycle strobe that ends the current chopper phase |
| usr_chan | input | 2 | User channel, used when the chopper is off |
| usr_gain | input | 2 | User gain code |
| smp_valid | input | 1 | Marks a valid converted sample |
| smp_data | input | 16 | Signed sample from the converter |
| mux_sel | output | 2 | Multiplexer channel select |
| gain_code | output | 2 | Amplifier gain lines |
| neg_flag | output | 1 | High while samples are being negated |
| out_valid | output | 1 | Marks a valid demodulated sample |
| out_data | output | 16 | Signed demodulated sample |

## Verification
The hardest case to reach is the most negative sample arriving in a reversed phase. A sample that coincides with a phase strobe, or a strobe in the same cycle the chopper is enabled, is nearly as hard. Each of these needs the phase counter to be in a particular state at the moment a particular data value appears. The stimulus first drives these cases by hand: it enables the chopper with a strobe, steps into phase 1, and feeds the extreme codes. It then runs a long random sequence. This sequence toggles the enable rarely, sends strobes often, and biases the data toward the two extreme codes, so the same collisions come up many more times in varied phase positions.

// File: rtl/chop_pkg.sv
package chop_pkg;

  localparam int PHASES = 4;

  // Phase index of one chopper period; odd phases use the reversed input.
  typedef enum logic [1:0] {
    PH_A0 = 2'd0,
    PH_B0 = 2'd1,
    PH_A1 = 2'd2,
    PH_B1 = 2'd3
  } phase_e;

  function automatic logic phase_is_rev(input phase_e p);
    return p[0];
  endfunction

endpackage

// File: rtl/chop_phase_ctr.sv
module chop_phase_ctr
  import chop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   chop_en,
  input  logic   phase_adv,
  output phase_e phase_q,
  output phase_e phase_nx,
  output logic   en_q
);

  always_comb begin
    phase_nx = phase_q;
    if (!chop_en || !en_q) begin
      phase_nx = PH_A0;
    end else if (phase_adv) begin
      phase_nx = phase_e'(phase_q + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_A0;
      en_q    <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      en_q    <= chop_en;
    end
  end

  // R5: no strobe -> phase holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && chop_en && !phase_adv) |=> $stable(phase_q));

  // R5: strobe -> exactly one step
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && chop_en && phase_adv) |=> (phase_q == phase_e'($past(phase_q) + 2'd1)));

  // R6: enabling restarts the period
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_en && !en_q) |=> (phase_q == PH_A0));

endmodule

// File: rtl/chop_route.sv
module chop_route
  import chop_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int GAIN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chop_en,
  input  logic [CH_W-1:0]   usr_chan,
  input  logic [GAIN_W-1:0] usr_gain,
  input  phase_e            phase_nx,
  output logic [CH_W-1:0]   mux_sel,
  output logic [GAIN_W-1:0] gain_code,
  output logic              neg_flag,
  output logic              mode_q
);

  localparam logic [CH_W-1:0] CH_DIRECT  = '0;
  localparam logic [CH_W-1:0] CH_REVERSE = {{(CH_W-1){1'b0}}, 1'b1};

  logic [CH_W-1:0] sel_nx;
  logic            neg_nx;

  always_comb begin
    if (chop_en) begin
      neg_nx = phase_is_rev(phase_nx);
      sel_nx = neg_nx ? CH_REVERSE : CH_DIRECT;
    end else begin
      neg_nx = 1'b0;
      sel_nx = usr_chan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel   <= '0;
      gain_code <= '0;
      neg_flag  <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      mux_sel   <= sel_nx;
      gain_code <= usr_gain;
      neg_flag  <= neg_nx;
      mode_q    <= chop_en;
    end
  end

  p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !chop_en |=> (mux_sel == $past(usr_chan) && !neg_flag));

  p_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gain_code == $past(usr_gain)));

  // R4: pair restricted to codes 0/1, sign tied to the reversed input
  p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> ((mux_sel >> 1) == '0 && neg_flag == mux_sel[0]));

endmodule

// File: rtl/chop_demod.sv
module chop_demod #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic                     neg_flag,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);

  localparam logic signed [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [DATA_W-1:0] neg_val;
  logic signed [DATA_W-1:0] dat_nx;
  logic                     dat_en;

  always_comb begin
    neg_val = (smp_data == S_MIN) ? S_MAX : -smp_data;
    dat_nx  = neg_flag ? neg_val : smp_data;
    dat_en  = smp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= smp_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (dat_en) begin
      out_data <= dat_nx;
    end
  end

  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !neg_flag) |=> (out_data == $past(smp_data)));

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && neg_flag && smp_data == S_MIN) |=> (out_data == S_MAX));

  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(smp_valid)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(out_data));

endmodule

// File: rtl/chopper_mux_sequencer.sv
module chopper_mux_sequencer
  import chop_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int N_GAIN = 4,
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              chop_en,
  input  logic                              phase_adv,
  input  logic [$clog2(N_CH)-1:0]           usr_chan,
  input  logic [$clog2(N_GAIN)-1:0]         usr_gain,
  input  logic                              smp_valid,
  input  logic signed [DATA_W-1:0]          smp_data,
  output logic [$clog2(N_CH)-1:0]           mux_sel,
  output logic [$clog2(N_GAIN)-1:0]         gain_code,
  output logic                              neg_flag,
  output logic                              out_valid,
  output logic signed [DATA_W-1:0]          out_data
);

  localparam int CH_W   = $clog2(N_CH);
  localparam int GAIN_W = $clog2(N_GAIN);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_sync;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_in_n = rst_sync[1];

  phase_e phase_q;
  phase_e phase_nx;
  logic   en_q;
  logic   mode_q;

  chop_phase_ctr u_phase (
    .clk      (clk),
    .rst_n    (rst_in_n),
    .chop_en  (chop_en),
    .phase_adv(phase_adv),
    .phase_q  (phase_q),
    .phase_nx (phase_nx),
    .en_q     (en_q)
  );

  chop_route #(.CH_W(CH_W), .GAIN_W(GAIN_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_in_n),
    .chop_en  (chop_en),
    .usr_chan (usr_chan),
    .usr_gain (usr_gain),
    .phase_nx (phase_nx),
    .mux_sel  (mux_sel),
    .gain_code(gain_code),
    .neg_flag (neg_flag),
    .mode_q   (mode_q)
  );

  chop_demod #(.DATA_W(DATA_W)) u_demod (
    .clk      (clk),
    .rst_n    (rst_in_n),
    .smp_valid(smp_valid),
    .smp_data (smp_data),
    .neg_flag (neg_flag),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  // R4: counter phase and routed sign agree while chopping
  p_phase_sign_r4: assert property (@(posedge clk) disable iff (!rst_in_n)
    (mode_q && en_q) |-> (neg_flag == phase_is_rev(phase_q)));

  // R1: outputs idle while held in reset
  p_reset_r1: assert property (@(posedge clk)
    !rst_in_n |-> (!out_valid && !neg_flag && mux_sel == '0));

endmodule

// File: tb/sim_chopper_mux_sequencer.sv
module sim_chopper_mux_sequencer;

  localparam int DW = 16;
  localparam int HALF = 10;
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chop_en = 1'b0, phase_adv = 1'b0, smp_valid = 1'b0;
  logic [1:0] usr_chan = '0, usr_gain = '0;
  logic signed [DW-1:0] smp_data = '0;
  logic [1:0] mux_sel, gain_code;
  logic neg_flag, out_valid;
  logic signed [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;

  // model state
  int m_phase = 0;
  bit m_en_q = 0;
  int exp_sel = 0, exp_gain = 0;
  bit exp_neg = 0, exp_vld = 0;
  logic signed [DW-1:0] exp_dat = '0;
  string dat_tag = "R7";

  always #HALF clk = ~clk;

  chopper_mux_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .chop_en(chop_en), .phase_adv(phase_adv),
    .usr_chan(usr_chan), .usr_gain(usr_gain), .smp_valid(smp_valid),
    .smp_data(smp_data), .mux_sel(mux_sel), .gain_code(gain_code),
    .neg_flag(neg_flag), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic signed [DW-1:0] ref_neg(input logic signed [DW-1:0] x);
    return (x == MINV) ? MAXV : -x;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Model one clock edge using the inputs currently driven.
  task automatic model_step();
    exp_vld = smp_valid;
    if (smp_valid) begin
      dat_tag = (exp_neg && smp_data == MINV) ? "R8" : "R7";
      exp_dat = exp_neg ? ref_neg(smp_data) : smp_data;
    end else begin
      dat_tag = "R9";
    end
    if (!chop_en || !m_en_q) m_phase = 0;
    else if (phase_adv)      m_phase = (m_phase + 1) % 4;
    m_en_q   = chop_en;
    exp_gain = usr_gain;
    if (chop_en) begin
      exp_sel = m_phase % 2;
      exp_neg = (m_phase % 2) == 1;
    end else begin
      exp_sel = usr_chan;
      exp_neg = 0;
    end
  endtask

  task automatic check_all();
    chk(m_en_q ? "R4 mux" : "R2 mux", mux_sel, exp_sel);
    chk(m_en_q ? "R4 sign" : "R2 sign", neg_flag, exp_neg);
    chk("R3 gain", gain_code, exp_gain);
    chk("R9 valid", out_valid, exp_vld);
    chk({dat_tag, " data"}, out_data, exp_dat);
  endtask

  // Inputs were set at a negedge; step the model, pass one edge, compare.
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic drive(input bit en, input bit adv, input bit v,
                       input logic signed [DW-1:0] d);
    chop_en = en; phase_adv = adv; smp_valid = v; smp_data = d;
    cyc();
  endtask

  initial begin
    void'($urandom(32'h1c0ffee));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 mux", mux_sel, 0);
    chk("R1 gain", gain_code, 0);
    chk("R1 sign", neg_flag, 0);
    chk("R1 valid", out_valid, 0);
    chk("R1 data", out_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mux after release", mux_sel, 0);
    chk("R1 valid after release", out_valid, 0);
    repeat (2) @(negedge clk);

    // R2/R3: chopper off, every channel and gain
    for (int c = 0; c < 4; c++) begin
      usr_chan = 2'(c); usr_gain = 2'(3 - c);
      drive(0, 1, 1, 16'sd100 + 16'(c));
      chk("R2 direct channel", mux_sel, c);
    end

    // R6: enable with a strobe in the same cycle -> phase 0
    usr_chan = 2'd3;
    drive(1, 1, 1, 16'sd5);
    chk("R6 restart channel", mux_sel, 0);
    // R5: strobe moves to phase 1
    drive(1, 1, 0, 16'sd0);
    chk("R5 advance", mux_sel, 1);
    // R5: no strobe -> hold
    for (int i = 0; i < 3; i++) begin
      drive(1, 0, 0, 16'sd0);
      chk("R5 hold", mux_sel, 1);
    end
    // R8: most negative sample in reversed phase
    drive(1, 0, 1, MINV);
    chk("R8 saturate", out_data, MAXV);
    drive(1, 0, 1, MAXV);
    chk("R7 negate max", out_data, -MAXV);
    // R7: sample with strobe belongs to ending phase (reversed)
    drive(1, 1, 1, 16'sd300);
    chk("R7 tag at boundary", out_data, -300);
    // R9: no sample -> data holds
    drive(1, 0, 0, 16'sd77);
    chk("R9 hold data", out_data, -300);
    // R4: full sequence over four strobes
    for (int i = 0; i < 4; i++) drive(1, 1, 0, 16'sd0);
    // R6: drop and re-enable restarts
    drive(0, 0, 0, 16'sd0);
    drive(1, 1, 1, MINV);
    chk("R6 re-enable channel", mux_sel, 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic signed [DW-1:0] d;
      int r;
      r = int'($urandom_range(15));
      if (r == 0)      d = MINV;
      else if (r == 1) d = MAXV;
      else             d = DW'($urandom);
      usr_chan = 2'($urandom);
      usr_gain = 2'($urandom);
      drive(($urandom_range(63) == 0) ? ~chop_en : chop_en,
            $urandom_range(3) == 0, $urandom_range(3) != 0, d);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(2 * HALF * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule